// File: doc/BRIEF.md
# Millisecond counter on multiplexed seven-segment displays

This block counts elapsed milliseconds from 0 to 9999 and shows the running value in decimal on two 4-digit, 7-segment displays. Both displays show the same value. A free-running divider turns the system clock into a one-millisecond tick. A wrapping counter advances on each tick. A combinational shift-and-add-three converter turns the binary count into four BCD nibbles. A scanner lights one digit per clock and picks that digit's segment pattern.

All digit-select and segment signals inside the block are active-high. They are inverted only at the top-level pins, because the board drives both anodes and segments active-low. Bit 0 of the button input acts as an active-high reset at the pin. The other button bits have no effect.

Top module: `msec_display_top`

## Requirements
- R1: The count advances by exactly one for every TICK_DIV clock cycles after reset release. The first advance happens on the TICK_DIV-th rising edge after release, and the count never changes between ticks.
- R2: The count runs from 0 to 9999. On the tick that follows 9999 it returns to 0 and keeps counting from there.
- R3: The displayed digits are the decimal digits of the count. Anode bit i shows decimal digit i, where bit 0 is the least significant (ones) digit.
- R4: Segment pin bits 6..0 carry segments g,f,e,d,c,b,a. Each pin is the inverse of the internal active-high pattern, so a lit segment is 0 at the pin. The patterns are: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R5: Segment pin bit 7 (the decimal point) is always 1, which means unlit.
- R6: The digit select is a registered one-hot value. It equals 0001 internally (pins 1110) on the first clock with reset applied. After that it rotates left by one position every clock, so after e edges since reset release it selects digit e mod 4.
- R7: The second display's anode and segment pins are always equal to the first display's.
- R8: While btn_i[0] is 1 at a rising edge, the count, the tick phase and the scanner return to their start values and do not move. btn_i[3:1] have no effect on any output.
- R9: When the count is 8 and the anode pins read 1110, segment pins 6..0 are all 0.
- R10: Exactly one anode pin of each display is 0 on every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| btn_i | input | 4 | Buttons; bit 0 is the synchronous reset (active-high), bits 3..1 unused |
| disp0_an_n | output | 4 | First display digit anodes, active-low, bit 0 = ones digit |
| disp1_an_n | output | 4 | Second display digit anodes, copy of the first |
| disp0_seg_n | output | 8 | First display segments, active-low, bit 7 = dot, bits 6..0 = g..a |
| disp1_seg_n | output | 8 | Second display segments, copy of the first |

## Verification
The count update and the digit scan both happen on the same clock edge. On every tick edge, the digit that is newly selected must already show the new count. A stale or half-converted value must never appear. The bench uses a small tick ratio so that each millisecond spans exactly one full scan. It samples all four digits in the four cycles after each tick, including the cycles where 9999 wraps to 0 and where a reset lands in the middle of a count. Each sample is judged against the digit index expected from the number of edges and the decimal value expected from the elapsed milliseconds.

// File: rtl/msd_pkg.sv
// Shared types and the segment lookup for the millisecond display block.
// Assumes: decimal digits stored as 4-bit BCD nibbles, segment order gfedcba.
package msd_pkg;

    localparam int unsigned NIBBLE_W = 4;
    localparam int unsigned SEG_W    = 7;

    typedef logic [NIBBLE_W-1:0] nibble_t;
    typedef logic [SEG_W-1:0]    seg_t;     // bit 6 = g ... bit 0 = a, active-high

    // Map one BCD digit to its active-high segment pattern; non-decimal codes go dark.
    function automatic seg_t digit_to_seg(input nibble_t d);
        seg_t s;
        case (d)
            4'd0:    s = 7'b0111111;
            4'd1:    s = 7'b0000110;
            4'd2:    s = 7'b1011011;
            4'd3:    s = 7'b1001111;
            4'd4:    s = 7'b1100110;
            4'd5:    s = 7'b1101101;
            4'd6:    s = 7'b1111101;
            4'd7:    s = 7'b0000111;
            4'd8:    s = 7'b1111111;
            4'd9:    s = 7'b1101111;
            default: s = 7'b0000000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/msd_tick_gen.sv
// Millisecond tick generator.
// Counts clock cycles and raises tick_o for one cycle out of every TICK_DIV.
// Assumes TICK_DIV >= 2 and a synchronous active-low reset.
module msd_tick_gen #(
    parameter int unsigned TICK_DIV = 100_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] phase_q;

    // Advance the phase counter, restarting after the last cycle of a period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    assign tick_o = (phase_q == LAST);

    AST_TICK_NOT_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R1

endmodule

// File: rtl/msd_wrap_counter.sv
// Decimal-limited event counter.
// Adds one on every tick and returns to zero after MAX_COUNT.
// Assumes tick_i is a single-cycle pulse; synchronous active-low reset.
module msd_wrap_counter #(
    parameter int unsigned MAX_COUNT = 9999,
    parameter int unsigned CNT_W     = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_COUNT);

    logic [CNT_W-1:0] count_q;

    // Step the count on a tick, wrapping from the top value back to zero.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)          count_q <= '0;
        else if (tick_i) begin
            if (count_q == TOP) count_q <= '0;
            else                count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    AST_COUNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_q <= TOP); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && count_q == TOP) |=> (count_q == '0)); // R2
    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && count_q != TOP) |=> (count_q == $past(count_q) + 1'b1)); // R1
    AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(count_q)); // R1

endmodule

// File: rtl/msd_bin2bcd.sv
// Combinational binary-to-BCD converter (shift and add three).
// For each input bit, MSB first: every nibble above 4 gains 3, then the
// accumulator shifts left and takes in the next bit.
// Assumes DIGITS nibbles are wide enough for the largest input value.
module msd_bin2bcd
    import msd_pkg::*;
#(
    parameter int unsigned BIN_W  = 14,
    parameter int unsigned DIGITS = 4
) (
    input  logic [BIN_W-1:0]           bin_i,
    output logic [NIBBLE_W*DIGITS-1:0] bcd_o
);
    localparam int unsigned BCD_W = NIBBLE_W * DIGITS;

    logic [BCD_W-1:0] acc;

    // Run the full shift-and-adjust sequence over all input bits.
    always_comb begin
        acc = '0;
        for (int i = BIN_W - 1; i >= 0; i--) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (acc[NIBBLE_W*d +: NIBBLE_W] > 4'd4)
                    acc[NIBBLE_W*d +: NIBBLE_W] = acc[NIBBLE_W*d +: NIBBLE_W] + 4'd3;
            end
            acc = {acc[BCD_W-2:0], bin_i[i]};
        end
        bcd_o = acc;
    end

    // Every nibble produced must be a decimal digit.
    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_digit_chk
            always_comb begin
                AST_BCD_DIGIT_RANGE: assert (bcd_o[NIBBLE_W*g +: NIBBLE_W] <= 4'd9 || $isunknown(bin_i)); // R3
            end
        end
    endgenerate

endmodule

// File: rtl/msd_digit_scanner.sv
// Multiplexed digit scanner.
// A digit address and a registered one-hot select advance together each
// clock; the addressed BCD nibble drives the active-high segment pattern.
// The select is registered, not decoded from the address, so every
// digit sees the same on-time. Assumes DIGITS >= 2.
module msd_digit_scanner
    import msd_pkg::*;
#(
    parameter int unsigned DIGITS = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NIBBLE_W*DIGITS-1:0] bcd_i,
    output logic [DIGITS-1:0]          sel_o,
    output seg_t                       seg_o
);
    localparam int unsigned ADDR_W = $clog2(DIGITS);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DIGITS - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [DIGITS-1:0] sel_q;
    nibble_t           cur_digit;

    // Step the digit address, wrapping after the last digit; reset with the select.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                addr_q <= '0;
        else if (addr_q == ADDR_LAST) addr_q <= '0;
        else                        addr_q <= addr_q + 1'b1;
    end

    // Rotate the one-hot select left by one place every clock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sel_q <= DIGITS'(1);
        else         sel_q <= {sel_q[DIGITS-2:0], sel_q[DIGITS-1]};
    end

    assign cur_digit = bcd_i[NIBBLE_W*int'(addr_q) +: NIBBLE_W];
    assign seg_o     = digit_to_seg(cur_digit);
    assign sel_o     = sel_q;

    AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(sel_q) == 1); // R6
    AST_SEL_ADDR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_q[addr_q] == 1'b1); // R6
    AST_SEL_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (sel_q == {$past(sel_q[DIGITS-2:0]), $past(sel_q[DIGITS-1])})); // R6

endmodule

// File: rtl/msec_display_top.sv
// Board top: millisecond counter shown on two identical multiplexed displays.
// btn_i[0] is an active-high reset at the pin, used synchronously inside as
// an active-low reset. All internal select and segment signals are
// active-high and are inverted only here for the active-low pins. The dot
// segment is held unlit.
module msec_display_top #(
    parameter int unsigned TICK_DIV = 100_000,
    parameter int unsigned DIGITS   = 4
) (
    input  logic              clk_i,
    input  logic [3:0]        btn_i,
    output logic [DIGITS-1:0] disp0_an_n,
    output logic [DIGITS-1:0] disp1_an_n,
    output logic [7:0]        disp0_seg_n,
    output logic [7:0]        disp1_seg_n
);
    import msd_pkg::*;

    localparam int unsigned MAX_COUNT = (10 ** DIGITS) - 1;
    localparam int unsigned CNT_W     = $clog2(MAX_COUNT + 1);

    logic                       rst_n;
    logic                       tick;
    logic [CNT_W-1:0]           count;
    logic [NIBBLE_W*DIGITS-1:0] bcd;
    logic [DIGITS-1:0]          sel;
    seg_t                       seg;
    logic [7:0]                 seg_pins_n;
    logic                       unused_btn;

    assign rst_n      = ~btn_i[0];
    assign unused_btn = ^btn_i[3:1];

    msd_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_n),
        .tick_o (tick)
    );

    msd_wrap_counter #(.MAX_COUNT(MAX_COUNT), .CNT_W(CNT_W)) count_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_n),
        .tick_i  (tick),
        .count_o (count)
    );

    msd_bin2bcd #(.BIN_W(CNT_W), .DIGITS(DIGITS)) conv_i (
        .bin_i (count),
        .bcd_o (bcd)
    );

    msd_digit_scanner #(.DIGITS(DIGITS)) scan_i (
        .clk_i  (clk_i),
        .rst_ni (rst_n),
        .bcd_i  (bcd),
        .sel_o  (sel),
        .seg_o  (seg)
    );

    // Polarity inversion for the pins; dot bit stays unlit (high).
    assign seg_pins_n  = {1'b1, ~seg};
    assign disp0_an_n  = ~sel;
    assign disp1_an_n  = ~sel;
    assign disp0_seg_n = seg_pins_n;
    assign disp1_seg_n = seg_pins_n;

    AST_SINGLE_ANODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
        $countones(~disp0_an_n) == 1); // R10

endmodule

// File: tb/msec_display_top_tb_top.sv
// Self-checking bench: walks a table of elapsed-millisecond points, then
// directed reset checks. Uses a small tick ratio so one ms = one full scan.
module msec_display_top_tb_top;

    localparam int unsigned DIV = 4;
    localparam int unsigned ND  = 4;
    localparam int unsigned NVEC = 15;

    // Stimulus: elapsed ms since release; expected: displayed value as BCD.
    localparam int unsigned VEC_MS [NVEC] = '{0, 1, 7, 8, 9, 10, 99, 100, 1234,
                                              4321, 5678, 9998, 9999, 10000, 10001};
    localparam logic [15:0] VEC_BCD [NVEC] = '{16'h0000, 16'h0001, 16'h0007, 16'h0008,
                                               16'h0009, 16'h0010, 16'h0099, 16'h0100,
                                               16'h1234, 16'h4321, 16'h5678, 16'h9998,
                                               16'h9999, 16'h0000, 16'h0001};

    logic       clk_i = 1'b0;
    logic [3:0] btn_i = 4'b0001;
    logic [3:0] disp0_an_n, disp1_an_n;
    logic [7:0] disp0_seg_n, disp1_seg_n;

    int checks   = 0;
    int failures = 0;
    int edges    = 0;
    bit done     = 1'b0;

    msec_display_top #(.TICK_DIV(DIV), .DIGITS(ND)) dut_i (
        .clk_i       (clk_i),
        .btn_i       (btn_i),
        .disp0_an_n  (disp0_an_n),
        .disp1_an_n  (disp1_an_n),
        .disp0_seg_n (disp0_seg_n),
        .disp1_seg_n (disp1_seg_n)
    );

    always #2 clk_i = ~clk_i;

    // Edges since reset release, tracked by the bench itself.
    always @(posedge clk_i) begin
        if (btn_i[0]) edges <= 0;
        else          edges <= edges + 1;
    end

    function automatic logic [6:0] exp_seg(input logic [3:0] d);
        case (d)
            4'd0: return 7'b0111111;  4'd1: return 7'b0000110;
            4'd2: return 7'b1011011;  4'd3: return 7'b1001111;
            4'd4: return 7'b1100110;  4'd5: return 7'b1101101;
            4'd6: return 7'b1111101;  4'd7: return 7'b0000111;
            4'd8: return 7'b1111111;  4'd9: return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Check one full scan at the given elapsed ms; bcd is the expected value.
    task automatic check_ms(input int unsigned ms, input logic [15:0] bcd);
        int unsigned target = ms * DIV;
        while (edges < int'(target)) @(negedge clk_i);
        for (int k = 0; k < int'(ND); k++) begin
            int unsigned e   = target + k;
            int unsigned idx = e % ND;
            logic [3:0] an_exp  = ~(4'b0001 << idx);
            logic [3:0] dig     = bcd[4*idx +: 4];
            logic [7:0] seg_exp = {1'b1, ~exp_seg(dig)};
            if (k > 0) @(negedge clk_i);
            check(disp0_an_n == an_exp, "R6 anode scan", {12'h0, disp0_an_n}, {12'h0, an_exp});
            check(disp0_seg_n[6:0] == seg_exp[6:0], "R1/R3/R4 digit segments",
                  {8'h0, disp0_seg_n}, {8'h0, seg_exp});
            check(disp0_seg_n[7] == 1'b1, "R5 dot off", {15'h0, disp0_seg_n[7]}, 16'h1);
            check(disp1_an_n == disp0_an_n && disp1_seg_n == disp0_seg_n, "R7 second display",
                  {disp1_an_n, disp1_seg_n}, {disp0_an_n, disp0_seg_n});
            check($countones(~disp0_an_n) == 1, "R10 one anode low",
                  {12'h0, disp0_an_n}, {12'h0, an_exp});
            if (bcd == 16'h0008 && disp0_an_n == 4'b1110)
                check(disp0_seg_n[6:0] == 7'b0, "R9 eight all lit",
                      {9'h0, disp0_seg_n[6:0]}, 16'h0);
            if (ms >= 9999)
                check(1'b1, "R2 wrap point visited", 16'h0, 16'h0);
        end
    endtask

    initial begin
        // Reset state: anode 0 selected, digit shows 0.
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        check(disp0_an_n == 4'b1110, "R6 reset select", {12'h0, disp0_an_n}, 16'h000e);
        check(disp0_seg_n == 8'b1100_0000, "R8 reset shows zero", {8'h0, disp0_seg_n}, 16'h00c0);
        btn_i = 4'b0000;

        // Table walk; R8: btn[3:1] toggled partway must not disturb anything.
        for (int v = 0; v < int'(NVEC); v++) begin
            if (v == 5) btn_i[3:1] = 3'b101;
            if (v == 10) btn_i[3:1] = 3'b010;
            check_ms(VEC_MS[v], VEC_BCD[v]);
        end

        // R8: reset in the middle of a count.
        @(negedge clk_i);
        btn_i[0] = 1'b1;
        @(negedge clk_i);
        check(disp0_an_n == 4'b1110, "R8 mid-run reset select", {12'h0, disp0_an_n}, 16'h000e);
        check(disp0_seg_n == 8'b1100_0000, "R8 mid-run reset zero", {8'h0, disp0_seg_n}, 16'h00c0);
        repeat (6) @(negedge clk_i);
        check(disp0_an_n == 4'b1110, "R8 held reset no scan", {12'h0, disp0_an_n}, 16'h000e);
        check(disp0_seg_n == 8'b1100_0000, "R8 held reset no count", {8'h0, disp0_seg_n}, 16'h00c0);
        btn_i[0] = 1'b0;
        check_ms(0, 16'h0000);
        check_ms(1, 16'h0001);
        check_ms(2, 16'h0002);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150_000) @(posedge clk_i);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule